// File: doc/BRIEF.md
# Register Window Index Translator

This block turns an architectural integer register number into a physical index of a register file that holds windowed registers and banked globals. It keeps two small pieces of state: the window pointer and the global level. Each has its own write port. From these it presents three views of the register file: the current window, the next window (pointer minus one) and the previous window (pointer plus one). Each view has eight global slots followed by twenty-four windowed slots. A microcode register region follows the three views.

Any number of query lanes (parameter `NQ`) can be served at once. Each lane is a purely combinational lookup from the registered pointer and level. The register storage, the spill and fill handling and the save/restore bookkeeping belong to other blocks.

The physical file holds 32 global entries (4 levels of 8) at indices 0..31 and 128 windowed entries at indices 32..159. The microcode registers follow at 160..167.

Top module: `rwin_xlate`

## Requirements
- R1: After a synchronous reset, the window pointer and the global level both read 0.
- R2: In every view and at every global level, slot 0 of the globals (architectural index 0, 32 or 64) maps to physical 0.
- R3: Global slot j, for j in 1..7, maps to physical j + 8*level. Each view uses the same level.
- R4: The current view occupies architectural indices 0..31. Its windowed slot i (architectural 8+i, i in 0..23) maps to 32 + ((i - 16*w + 128) mod 128), with w equal to the pointer.
- R5: The next view occupies architectural indices 32..63. Its windowed slots use w = pointer - 1, which wraps to 7 when the pointer is 0.
- R6: The previous view occupies architectural indices 64..95. Its windowed slots use w = pointer + 1, which wraps to 0 when the pointer is 7.
- R7: Architectural index 96+k (k in 0..7) is microcode register k and maps to physical 160+k.
- R8: A pointer write of a value of 8 or more stores 7. Writes of 0..7 are stored as given.
- R9: A pointer or level value is loaded only on a clock edge where its own write enable is high. With the enable low, the data on that port has no effect.
- R10: An architectural index of 104 or more maps to physical 0.
- R11: A lookup follows its query with no clock. A pointer or level write shows in every lookup from the edge that loads it.
- R12: Each query lane translates its own index, independent of the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwp_we | input | 1 | Window pointer write enable |
| cwp_wdata | input | 8 | Window pointer write value (clamped to 7) |
| gl_we | input | 1 | Global level write enable |
| gl_wdata | input | 2 | Global level write value |
| arch_idx | input | NQ*7 | Architectural index per lane, lane 0 in the low bits |
| phys_idx | output | NQ*8 | Physical index per lane, lane 0 in the low bits |
| cwp_o | output | 3 | Registered window pointer |
| gl_o | output | 2 | Registered global level |

## Verification
A wrong pointer or level shows on `cwp_o`/`gl_o` at the first edge after the write. It also shifts the physical index of every windowed or global slot from 1 to 7, so a full sweep of the architectural space exposes it. A fault in the wrap arithmetic appears only in the next view at pointer 0 and in the previous view at pointer 7. For that reason, these two pointer values are swept in full. Decode faults show at once and with no clock, because the lookup is combinational. The bench sweeps all indices on two lanes in opposite order, so a swapped lane or a region boundary that is off by one shows up.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
    localparam int NWIN      = 8;
    localparam int RPW       = 16;
    localparam int WIN_VIEW  = 24;
    localparam int MAX_GL    = 4;
    localparam int GPL       = 8;
    localparam int NUM_MICRO = 8;
    localparam int NUM_VIEWS = 3;

    localparam int TG         = GPL * MAX_GL;
    localparam int TW         = NWIN * RPW;
    localparam int VIEW_SPAN  = GPL + WIN_VIEW;
    localparam int MICRO_ARCH = NUM_VIEWS * VIEW_SPAN;
    localparam int ARCH_N     = MICRO_ARCH + NUM_MICRO;
    localparam int MICRO_PHYS = TG + TW;
    localparam int PHYS_N     = MICRO_PHYS + NUM_MICRO;

    localparam int AW     = $clog2(ARCH_N);
    localparam int PW     = $clog2(PHYS_N);
    localparam int CW     = $clog2(NWIN);
    localparam int GW     = $clog2(MAX_GL);
    localparam int WDW    = 8;
    localparam int VOFF_W = $clog2(VIEW_SPAN);

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] phys_t;
    typedef logic [CW-1:0] cwp_t;
    typedef logic [GW-1:0] gl_t;

    typedef enum logic [2:0] {
        RGN_CUR, RGN_NEXT, RGN_PREV, RGN_MICRO, RGN_NONE
    } rgn_e;

    typedef struct packed {
        rgn_e              rgn;
        logic [VOFF_W-1:0] off;
    } slot_t;

    function automatic phys_t glob_phys(int ent, int lvl);
        if (ent == 0) return '0;
        return phys_t'(ent + lvl * GPL);
    endfunction

    function automatic phys_t win_phys(int ent, int win);
        return phys_t'(TG + ((ent + TW - win * RPW) % TW));
    endfunction

    function automatic cwp_t adj_win(cwp_t w, int delta);
        return cwp_t'((int'(w) + NWIN + delta) % NWIN);
    endfunction
endpackage

// File: rtl/rwin_state.sv
module rwin_state
    import rwin_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           cwp_we,
    input  logic [WDW-1:0] cwp_wdata,
    input  logic           gl_we,
    input  gl_t            gl_wdata,
    output cwp_t           cwp_q,
    output gl_t            gl_q
);
    cwp_t cwp_clamped;

    always_comb begin
        if (cwp_wdata >= WDW'(NWIN))
            cwp_clamped = cwp_t'(NWIN - 1);
        else
            cwp_clamped = cwp_wdata[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            gl_q  <= '0;
        end else begin
            if (cwp_we) cwp_q <= cwp_clamped;
            if (gl_we)  gl_q  <= gl_wdata;
        end
    end
endmodule

// File: rtl/rwin_decode.sv
module rwin_decode
    import rwin_pkg::*;
(
    input  arch_t arch_i,
    output slot_t slot_o
);
    int ai;
    int vw;

    always_comb begin
        ai          = int'(arch_i);
        vw          = 0;
        slot_o.rgn  = RGN_NONE;
        slot_o.off  = '0;
        if (ai < MICRO_ARCH) begin
            vw         = ai / VIEW_SPAN;
            slot_o.off = VOFF_W'(ai % VIEW_SPAN);
            case (vw)
                0:       slot_o.rgn = RGN_CUR;
                1:       slot_o.rgn = RGN_NEXT;
                default: slot_o.rgn = RGN_PREV;
            endcase
        end else if (ai < ARCH_N) begin
            slot_o.rgn = RGN_MICRO;
            slot_o.off = VOFF_W'(ai - MICRO_ARCH);
        end
    end
endmodule

// File: rtl/rwin_lookup.sv
module rwin_lookup
    import rwin_pkg::*;
(
    input  slot_t slot_i,
    input  cwp_t  cwp_i,
    input  gl_t   gl_i,
    output phys_t phys_o
);
    cwp_t win_sel;

    always_comb begin
        case (slot_i.rgn)
            RGN_NEXT: win_sel = adj_win(cwp_i, -1);
            RGN_PREV: win_sel = adj_win(cwp_i, 1);
            default:  win_sel = cwp_i;
        endcase
    end

    always_comb begin
        phys_o = '0;
        if (slot_i.rgn == RGN_MICRO)
            phys_o = phys_t'(MICRO_PHYS + int'(slot_i.off));
        else if (slot_i.rgn != RGN_NONE) begin
            if (int'(slot_i.off) < GPL)
                phys_o = glob_phys(int'(slot_i.off), int'(gl_i));
            else
                phys_o = win_phys(int'(slot_i.off) - GPL, int'(win_sel));
        end
    end
endmodule

// File: rtl/rwin_xlate.sv
module rwin_xlate
    import rwin_pkg::*;
#(
    parameter int NQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cwp_we,
    input  logic [WDW-1:0]   cwp_wdata,
    input  logic             gl_we,
    input  logic [GW-1:0]    gl_wdata,
    input  logic [NQ*AW-1:0] arch_idx,
    output logic [NQ*PW-1:0] phys_idx,
    output logic [CW-1:0]    cwp_o,
    output logic [GW-1:0]    gl_o
);
    cwp_t cwp_r;
    gl_t  gl_r;

    rwin_state u_state (
        .clk       (clk),
        .rst       (rst),
        .cwp_we    (cwp_we),
        .cwp_wdata (cwp_wdata),
        .gl_we     (gl_we),
        .gl_wdata  (gl_wdata),
        .cwp_q     (cwp_r),
        .gl_q      (gl_r)
    );

    assign cwp_o = cwp_r;
    assign gl_o  = gl_r;

    for (genvar q = 0; q < NQ; q++) begin : g_lane
        slot_t slot;
        phys_t phys;

        rwin_decode u_dec (
            .arch_i (arch_idx[q*AW +: AW]),
            .slot_o (slot)
        );

        rwin_lookup u_lk (
            .slot_i (slot),
            .cwp_i  (cwp_r),
            .gl_i   (gl_r),
            .phys_o (phys)
        );

        assign phys_idx[q*PW +: PW] = phys;
    end
endmodule

// File: rtl/rwin_xlate_chk.sv
module rwin_xlate_chk
    import rwin_pkg::*;
#(
    parameter int NQ = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cwp_we,
    input logic [WDW-1:0]   cwp_wdata,
    input logic             gl_we,
    input logic [GW-1:0]    gl_wdata,
    input logic [NQ*AW-1:0] arch_idx,
    input logic [NQ*PW-1:0] phys_idx,
    input logic [CW-1:0]    cwp_o,
    input logic [GW-1:0]    gl_o
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (cwp_o == '0 && gl_o == '0));

    assert_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        (cwp_we && cwp_wdata >= WDW'(NWIN)) |=> cwp_o == CW'(NWIN - 1));

    assert_cwp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cwp_we |=> $stable(cwp_o));

    assert_gl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !gl_we |=> $stable(gl_o));

    assert_gl_load_R9: assert property (@(posedge clk) disable iff (rst)
        gl_we |=> gl_o == $past(gl_wdata));

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        logic [AW-1:0] a_q;
        logic [PW-1:0] p_q;
        assign a_q = arch_idx[q*AW +: AW];
        assign p_q = phys_idx[q*PW +: PW];

        assert_glob_zero_R2: assert property (@(posedge clk) disable iff (rst)
            (a_q == AW'(0) || a_q == AW'(VIEW_SPAN) || a_q == AW'(2 * VIEW_SPAN))
            |-> p_q == '0);

        assert_micro_map_R7: assert property (@(posedge clk) disable iff (rst)
            (a_q >= AW'(MICRO_ARCH) && a_q < AW'(ARCH_N))
            |-> p_q == PW'(a_q) + PW'(MICRO_PHYS - MICRO_ARCH));

        assert_out_of_range_R10: assert property (@(posedge clk) disable iff (rst)
            a_q >= AW'(ARCH_N) |-> p_q == '0);
    end
endmodule

bind rwin_xlate rwin_xlate_chk #(.NQ(NQ)) chk_i (.*);

// File: tb/rwin_xlate_tb.sv
`timescale 1ns/1ps
module rwin_xlate_tb_top;
    import rwin_pkg::*;

    localparam int NQ   = 2;
    localparam int LAST = ARCH_N + 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cwp_we = 1'b0;
    logic [WDW-1:0]   cwp_wdata = '0;
    logic             gl_we = 1'b0;
    logic [GW-1:0]    gl_wdata = '0;
    logic [NQ*AW-1:0] arch_idx = '0;
    logic [NQ*PW-1:0] phys_idx;
    logic [CW-1:0]    cwp_o;
    logic [GW-1:0]    gl_o;

    int n_chk = 0;
    int n_err = 0;
    int m_cwp = 0;
    int m_gl  = 0;
    bit live  = 1'b0;

    always #2.5 clk = ~clk;

    rwin_xlate #(.NQ(NQ)) dut_i (
        .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata), .arch_idx(arch_idx),
        .phys_idx(phys_idx), .cwp_o(cwp_o), .gl_o(gl_o)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model, updated per clock
    always @(posedge clk) begin
        if (rst) begin
            m_cwp <= 0;
            m_gl  <= 0;
        end else begin
            if (cwp_we) m_cwp <= (int'(cwp_wdata) > 7) ? 7 : int'(cwp_wdata);
            if (gl_we)  m_gl  <= int'(gl_wdata);
        end
    end

    // per-clock comparison of the state outputs
    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R9 pointer", int'(cwp_o), m_cwp);
            chk("R9 level", int'(gl_o), m_gl);
        end
    end

    function automatic int expect_phys(int a, int p, int g);
        int e, v, w;
        if (a >= 104) return 0;
        if (a >= 96) return a - 96 + 160;
        v = a / 32;
        e = a % 32;
        if (e == 0) return 0;
        if (e < 8) return e + 8 * g;
        w = p;
        if (v == 1) w = p - 1;
        if (v == 2) w = p + 1;
        return 32 + (((e - 8) - 16 * w + 256) % 128);
    endfunction

    function automatic string tag_of(int a);
        int e;
        if (a >= 104) return "R10";
        if (a >= 96) return "R7";
        e = a % 32;
        if (e == 0) return "R2";
        if (e < 8) return "R3";
        if (a < 32) return "R4";
        if (a < 64) return "R5";
        return "R6";
    endfunction

    task automatic sweep();
        for (int a = 0; a <= LAST; a++) begin
            int b;
            b = LAST - a;
            arch_idx = {AW'(b), AW'(a)};
            #0.2;
            chk(tag_of(a), int'(phys_idx[PW-1:0]), expect_phys(a, m_cwp, m_gl));
            chk({"R12 lane1 ", tag_of(b)}, int'(phys_idx[2*PW-1:PW]),
                expect_phys(b, m_cwp, m_gl));
        end
    endtask

    task automatic wr(bit cw, int cv, bit gw, int gv);
        cwp_we    = cw;
        cwp_wdata = WDW'(cv);
        gl_we     = gw;
        gl_wdata  = GW'(gv);
        @(posedge clk);
        @(negedge clk);
        cwp_we = 1'b0;
        gl_we  = 1'b0;
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        live = 1'b1;
        chk("R1 pointer", int'(cwp_o), 0);
        chk("R1 level", int'(gl_o), 0);
        sweep();

        // R11: write visible right after the loading edge
        arch_idx = {AW'(40), AW'(9)};
        wr(1'b1, 3, 1'b1, 2);
        chk("R11 cur", int'(phys_idx[PW-1:0]), expect_phys(9, 3, 2));
        chk("R11 next", int'(phys_idx[2*PW-1:PW]), expect_phys(40, 3, 2));
        arch_idx = {AW'(70), AW'(5)};
        #0.2;
        chk("R11 comb", int'(phys_idx[PW-1:0]), 5 + 16);
        sweep();

        wr(1'b1, 0, 1'b1, 1);   // next view wraps (R5)
        sweep();
        wr(1'b1, 7, 1'b1, 3);   // previous view wraps (R6)
        sweep();

        wr(1'b1, 2, 1'b0, 0);
        wr(1'b1, 200, 1'b0, 0);
        chk("R8 clamp 200", int'(cwp_o), 7);
        wr(1'b1, 1, 1'b0, 0);
        wr(1'b1, 8, 1'b0, 0);
        chk("R8 clamp 8", int'(cwp_o), 7);
        wr(1'b1, 5, 1'b0, 0);
        chk("R8 in range", int'(cwp_o), 5);

        wr(1'b0, 2, 1'b0, 1);   // enables low: data ignored
        chk("R9 pointer ignored", int'(cwp_o), 5);
        chk("R9 level ignored", int'(gl_o), 3);
        sweep();

        wr(1'b0, 0, 1'b1, 0);   // level change alone rebuilds every global view
        sweep();

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule